// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

This block counts hardware events for one processor core in two 32-bit counters. The core supplies a vector of one-cycle event strobes and a two-bit privilege context. Software selects, through one 64-bit control word, which strobe each counter follows and in which privilege contexts counting is allowed. The two counters are reached together as a single 64-bit counter word, with the upper counter in bits 63:32 and the lower counter in bits 31:0.

The privilege enables are shared by both counters, so neither counter can be stopped on its own. Software parks an idle counter on a reserved event code that never fires. Each counter latches an overflow flag when it wraps from all ones to zero. A masked OR of these flags drives a level interrupt. That interrupt stays high until software writes the control word, and any such write clears both flags.

Register access is a plain port: a write strobe, a one-bit select (0 = counter word, 1 = control word), write data and combinational read data. Writes take effect at the next rising clock edge.

Top module: `pmu_dual_counter`

## Requirements
- R1: Reading with select 0 returns {upper counter, lower counter}. A write with select 0 loads bits 63:32 into the upper counter and bits 31:0 into the lower counter, and the new values are visible one cycle later.
- R2: Each counter has a 12-bit event code: the lower counter's code sits in control bits 17:6 and the upper counter's in bits 30:19. A code c below NUM_EVT (16 by default) adds one to the counter in every enabled cycle in which evt_i[c] is high.
- R3: Counting is allowed only when the enable for the current context is set. priv_i 2'b00 (user) uses control bit 2, 2'b01 (supervisor) uses bit 1, 2'b10 (hypervisor) uses bit 3, and 2'b11 never counts. The same enables gate both counters.
- R4: A counter whose code is 0x220 (parked) or any other code of NUM_EVT or above holds its value whatever the strobes do, while the other counter keeps counting.
- R5: An increment that takes a counter from 0xFFFFFFFF to 0 sets that counter's overflow flag. When the control word is read, the lower counter's flag appears at bit 62 and the upper counter's flag at bit 63.
- R6: irq_o is high while some overflow flag is set and its interrupt enable is set: bit 4 for the lower counter, bit 5 for the upper. It stays high over idle cycles until the control word is written.
- R7: Any write of the control word, including a write of the unchanged value, clears both overflow flags and drops irq_o in the next cycle. The write also wins over an overflow in the same cycle.
- R8: A counter-word write in the same cycle as an increment loads the written value, and that cycle sets no overflow flag.
- R9: After reset both counters are 0, both event codes are 0x220, all enables are 0, both flags are 0 and irq_o is low.
- R10: The control word reads back its writable fields (bits 30:19, 17:6 and 5:1). Bits 0, 18 and 61:31 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event strobes from the core |
| priv_i | input | 2 | Current privilege context |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 = counter word, 1 = control word |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Selected register, read combinationally |
| irq_o | output | 1 | Level overflow interrupt |

## Verification
The assertions check on every cycle the relations that span one clock edge:
- a counter-word load wins over an increment;
- a counter moves by exactly one or holds;
- parked counters and the no-count context hold;
- a wrap raises the flag;
- flags and the interrupt persist until a control write, which clears them.

Only the bench's scenarios can show behaviour that needs real values. That covers the mapping of each of the sixteen codes to its strobe, the full table of enable and context combinations, the read-back layout with the reserved zeros, the interrupt masking per counter, and the reset contents.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W      = 32;
  localparam int REG_W      = 2 * CNT_W;
  localparam int CODE_W     = 12;
  localparam int LO_SEL_LSB = 6;
  localparam int UP_SEL_LSB = 19;
  localparam int SUP_EN_BIT = 1;
  localparam int USR_EN_BIT = 2;
  localparam int HYP_EN_BIT = 3;
  localparam int IE_LSB     = 4;
  localparam int ST_LSB     = 62;
  localparam logic [CODE_W-1:0] PARK_CODE = 12'h220;

  typedef enum logic [1:0] {
    CTX_USER = 2'b00,
    CTX_SUP  = 2'b01,
    CTX_HYP  = 2'b10,
    CTX_NONE = 2'b11
  } ctx_e;

  // bit position of the event-code field of counter idx (0 = lower)
  function automatic int sel_lsb(int idx);
    return (idx == 0) ? LO_SEL_LSB : UP_SEL_LSB;
  endfunction

  // bits of the control word that software can write
  function automatic logic [REG_W-1:0] keep_mask();
    logic [REG_W-1:0] m;
    m = '0;
    m[UP_SEL_LSB +: CODE_W] = '1;
    m[LO_SEL_LSB +: CODE_W] = '1;
    m[SUP_EN_BIT] = 1'b1;
    m[USR_EN_BIT] = 1'b1;
    m[HYP_EN_BIT] = 1'b1;
    m[IE_LSB +: 2] = 2'b11;
    return m;
  endfunction

  function automatic logic [REG_W-1:0] reset_ctrl();
    logic [REG_W-1:0] v;
    v = '0;
    v[UP_SEL_LSB +: CODE_W] = PARK_CODE;
    v[LO_SEL_LSB +: CODE_W] = PARK_CODE;
    return v;
  endfunction

  // shared privilege gate (R3)
  function automatic logic ctx_allows(logic [REG_W-1:0] c, ctx_e x);
    case (x)
      CTX_USER: return c[USR_EN_BIT];
      CTX_SUP:  return c[SUP_EN_BIT];
      CTX_HYP:  return c[HYP_EN_BIT];
      default:  return 1'b0;
    endcase
  endfunction

  // increment with carry out; the carry marks the wrap
  function automatic logic [CNT_W:0] bump(logic [CNT_W-1:0] v);
    return {1'b0, v} + {{CNT_W{1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/pmu_event_sel.sv
module pmu_event_sel
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 16
) (
  input  logic [CODE_W-1:0]  code_i,
  input  logic [NUM_EVT-1:0] evt_i,
  output logic               hit_o
);
  localparam int IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

  logic implemented;

  // parked and out-of-range codes never hit (R4)
  assign implemented = (code_i < CODE_W'(NUM_EVT)) && (code_i != PARK_CODE);
  assign hit_o = implemented && evt_i[code_i[IDX_W-1:0]];
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W:0] nxt;

  assign nxt    = bump(cnt_o);
  // a load in the same cycle suppresses the wrap (R8)
  assign wrap_o = inc_i && !load_i && nxt[CNT_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= nxt[CNT_W-1:0];
  end
endmodule

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
  import pmu_pkg::*;
#(
  parameter int NUM_CNT = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [REG_W-1:0]   wdata_i,
  input  logic [NUM_CNT-1:0] wrap_i,
  output logic [REG_W-1:0]   ctrl_o,
  output logic [NUM_CNT-1:0] status_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= reset_ctrl();
      status_o <= '0;
    end else if (wr_i) begin
      ctrl_o   <= wdata_i & keep_mask();
      status_o <= '0;                   // any write clears (R7)
    end else begin
      status_o <= status_o | wrap_i;    // sticky flags (R5)
    end
  end
endmodule

// File: rtl/pmu_dual_counter.sv
module pmu_dual_counter
  import pmu_pkg::*;
#(
  parameter int NUM_EVT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [1:0]         priv_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [63:0]        reg_wdata_i,
  output logic [63:0]        reg_rdata_o,
  output logic               irq_o
);
  localparam int NUM_CNT = 2;

  logic               cnt_wr;
  logic               ctrl_wr;
  logic               ctx_ok;
  logic [REG_W-1:0]   ctrl_q;
  logic [NUM_CNT-1:0] status;
  logic [NUM_CNT-1:0] hit;
  logic [NUM_CNT-1:0] inc;
  logic [NUM_CNT-1:0] wrap;
  logic [REG_W-1:0]   cnt_pair;
  logic [CODE_W-1:0]  code_w [NUM_CNT];

  assign cnt_wr  = reg_wr_i && !reg_sel_i;
  assign ctrl_wr = reg_wr_i && reg_sel_i;
  assign ctx_ok  = ctx_allows(ctrl_q, ctx_e'(priv_i));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_slot
    localparam int LSB = sel_lsb(g);
    logic [CNT_W-1:0] cnt;

    assign code_w[g] = ctrl_q[LSB +: CODE_W];

    pmu_event_sel #(.NUM_EVT(NUM_EVT)) u_sel (
      .code_i (code_w[g]),
      .evt_i  (evt_i),
      .hit_o  (hit[g])
    );

    assign inc[g] = ctx_ok && hit[g];

    pmu_counter u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (cnt_wr),
      .load_val_i (reg_wdata_i[g*CNT_W +: CNT_W]),
      .inc_i      (inc[g]),
      .cnt_o      (cnt),
      .wrap_o     (wrap[g])
    );

    assign cnt_pair[g*CNT_W +: CNT_W] = cnt;
  end

  pmu_ctrl_reg #(.NUM_CNT(NUM_CNT)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (ctrl_wr),
    .wdata_i  (reg_wdata_i),
    .wrap_i   (wrap),
    .ctrl_o   (ctrl_q),
    .status_o (status)
  );

  assign irq_o       = |(status & ctrl_q[IE_LSB +: NUM_CNT]);
  assign reg_rdata_o = reg_sel_i ? (ctrl_q | (REG_W'(status) << ST_LSB)) : cnt_pair;
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cnt_wr,
  input logic              ctrl_wr,
  input logic [REG_W-1:0]  wdata,
  input logic [1:0]        priv,
  input logic [1:0]        inc,
  input logic [REG_W-1:0]  cnt_pair,
  input logic [1:0]        status,
  input logic              irq,
  input logic [CODE_W-1:0] lo_code,
  input logic [CODE_W-1:0] up_code
);
  logic [CNT_W-1:0] lo, up;
  assign lo = cnt_pair[CNT_W-1:0];
  assign up = cnt_pair[REG_W-1:CNT_W];

  a_r8_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_pair == $past(wdata));

  a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && inc[0]) |=> lo == $past(lo) + 1'b1);

  a_r4_lo_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && lo_code == PARK_CODE) |=> $stable(lo));

  a_r4_up_parked: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && up_code == PARK_CODE) |=> $stable(up));

  a_r3_no_context: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && priv == 2'b11) |=> $stable(cnt_pair));

  a_r5_lo_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !ctrl_wr && inc[0] && lo == '1) |=> status[0]);

  a_r5_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !ctrl_wr && inc[1] && up == '1) |=> status[1]);

  a_r7_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (status == 2'b00) && !irq);

  a_r6_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !ctrl_wr) |=> irq);
endmodule

bind pmu_dual_counter pmu_checker u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .cnt_wr   (cnt_wr),
  .ctrl_wr  (ctrl_wr),
  .wdata    (reg_wdata_i),
  .priv     (priv_i),
  .inc      (inc),
  .cnt_pair (cnt_pair),
  .status   (status),
  .irq      (irq_o),
  .lo_code  (code_w[0]),
  .up_code  (code_w[1])
);

// File: tb/sim_pmu_dual_counter.sv
`timescale 1ns/1ps
module sim_pmu_dual_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt = '0;
  logic [1:0]  priv = 2'b00;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [63:0] wd = '0;
  logic [63:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pmu_dual_counter #(.NUM_EVT(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .priv_i(priv),
    .reg_wr_i(wr), .reg_sel_i(sel), .reg_wdata_i(wd),
    .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [63:0] mk_ctrl(int up, int lo, int en, int ie);
    return (64'(up & 12'hFFF) << 19) | (64'(lo & 12'hFFF) << 6) |
           (64'(ie & 3) << 4) | (64'(en & 7) << 1);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic cyc(bit w, bit s, logic [63:0] d, logic [15:0] e, logic [1:0] p);
    wr = w; sel = s; wd = d; evt = e; priv = p;
    @(posedge clk);
    @(negedge clk);
    wr = 1'b0; evt = '0;
  endtask

  task automatic steps(logic [15:0] e, logic [1:0] p, int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 64'd0, e, p);
  endtask

  task automatic rd(bit s, output logic [63:0] v);
    sel = s; wr = 1'b0;
    #1 v = rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    logic [63:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    rd(0, v); chk("R9 counters", v, 64'd0);
    rd(1, v); chk("R9 control", v, mk_ctrl(12'h220, 12'h220, 0, 0));
    chk("R9 irq", {63'd0, irq}, 64'd0);

    // R10 read-back mask
    cyc(1, 1, '1, 0, 0);
    rd(1, v); chk("R10 readback", v, mk_ctrl(12'hFFF, 12'hFFF, 7, 3));

    // R1 counter word layout
    cyc(1, 0, 64'h1234_5678_9ABC_DEF0, 0, 0);
    rd(0, v); chk("R1 counter load", v, 64'h1234_5678_9ABC_DEF0);

    // R2 sweep of every implemented code on both counters
    for (int k = 0; k < 16; k++) begin
      cyc(1, 1, mk_ctrl(15 - k, k, 2, 0), 0, 0);
      cyc(1, 0, 64'd0, 0, 0);
      steps(16'(1 << k), 2'b00, 3);
      steps(~16'(1 << k), 2'b00, 2);
      steps(16'hFFFF, 2'b00, 1);
      rd(0, v); chk($sformatf("R2 code %0d", k), v, {32'd3, 32'd4});
    end

    // R3 sweep of enables against contexts
    for (int e = 0; e < 8; e++) begin
      for (int p = 0; p < 4; p++) begin
        bit ok;
        ok = (p == 0) ? e[1] : (p == 1) ? e[0] : (p == 2) ? e[2] : 1'b0;
        cyc(1, 1, mk_ctrl(0, 0, e, 0), 0, 0);
        cyc(1, 0, 64'd0, 0, 0);
        steps(16'h0001, 2'(p), 2);
        rd(0, v);
        chk($sformatf("R3 en=%0d ctx=%0d", e, p), v, ok ? {32'd2, 32'd2} : 64'd0);
      end
    end

    // R4 parked and unimplemented codes
    cyc(1, 1, mk_ctrl(0, 12'h220, 7, 0), 0, 0);
    cyc(1, 0, 64'd0, 0, 0);
    steps(16'hFFFF, 2'b00, 5);
    rd(0, v); chk("R4 parked lower", v, {32'd5, 32'd0});
    cyc(1, 1, mk_ctrl(12'h010, 12'hFFF, 7, 0), 0, 0);
    cyc(1, 0, 64'd0, 0, 0);
    steps(16'hFFFF, 2'b01, 4);
    rd(0, v); chk("R4 unimplemented codes", v, 64'd0);

    // R5/R6 wrap flags and masked interrupt
    c = mk_ctrl(0, 0, 2, 1);
    cyc(1, 1, c, 0, 0);
    cyc(1, 0, {32'hFFFF_FFFF, 32'hFFFF_FFFE}, 0, 0);
    steps(16'h0001, 2'b00, 1);
    rd(0, v); chk("R5 upper wrapped", v, {32'd0, 32'hFFFF_FFFF});
    rd(1, v); chk("R5 upper flag", v, c | (64'd1 << 63));
    chk("R6 upper masked", {63'd0, irq}, 64'd0);
    steps(16'h0001, 2'b00, 1);
    rd(1, v); chk("R5 both flags", v, c | (64'd3 << 62));
    chk("R6 irq raised", {63'd0, irq}, 64'd1);
    steps(16'h0000, 2'b00, 4);
    chk("R6 irq held", {63'd0, irq}, 64'd1);

    // R7 rewrite of the same value clears
    cyc(1, 1, c, 0, 0);
    rd(1, v); chk("R7 flags cleared", v, c);
    chk("R7 irq cleared", {63'd0, irq}, 64'd0);

    // R7 write wins over a same-cycle wrap
    cyc(1, 0, {32'd0, 32'hFFFF_FFFF}, 0, 0);
    cyc(1, 1, c, 16'h0001, 2'b00);
    rd(0, v); chk("R7 counted through write", v, {32'd1, 32'd0});
    rd(1, v); chk("R7 wrap dropped", v, c);
    chk("R7 irq low", {63'd0, irq}, 64'd0);

    // R8 load wins over increment, no flag
    cyc(1, 0, {32'hFFFF_FFFF, 32'hFFFF_FFFF}, 0, 0);
    cyc(1, 0, {32'd7, 32'd5}, 16'h0001, 2'b00);
    rd(0, v); chk("R8 load priority", v, {32'd7, 32'd5});
    rd(1, v); chk("R8 no flag", v, c);
    chk("R8 irq low", {63'd0, irq}, 64'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule